// File: doc/BRIEF.md
# Negative Exponential Evaluator (Shift-Add Hyperbolic Rotation)

The block evaluates e^(−z) for a nonnegative fixed-point argument z. It is built for the last stage of a Gaussian kernel, where z holds a scaled squared distance d²/(2σ²) and the result is the kernel value. The datapath uses only adders, subtractors, comparators and shifters, with a small table of arctanh constants. There is no hardware multiplier and no data memory.

Basic hyperbolic rotation converges only for |z| up to about 1.1. Gaussian kernels produce far larger exponents, so the block first splits z into k·ln2 + f with f in [0, ln2). It does this with one compare-and-subtract per clock, one bit of k at a time. It then rotates f to get cosh f and sinh f. The x register starts at the inverse of the hyperbolic gain, so no scaling step follows. The block forms cosh f − sinh f = e^(−f) and shifts that right by k bits. One iteration runs per clock. When the evaluation ends, a done flag rises, and the result stays on the output until the next start.

The argument has W bits, ZF of which are fraction bits. The result is unsigned, with W−1 fraction bits, so 1.0 is coded as 2^(W−1). The parameter G sets the number of internal guard bits. The internal fraction width is FB = W−1+G. The 14-bit and 12-bit word configurations both have to work.

Top module: `ncx_exp_neg`

## Requirements
- R1: After reset, `res_o` is 0 and `done_o` is 0.
- R2: For 0 ≤ z < ln2, the result is within 2 LSB of round(e^(−z)·2^(W−1)). Here z = z_i/2^ZF.
- R3: When floor(z/ln2) ≥ W, the result is exactly 0.
- R4: For ln2 ≤ z < W·ln2, the result is within 2 LSB of round(e^(−z)·2^(W−1)). This covers arguments well beyond the basic hyperbolic convergence limit.
- R5: `done_o` rises exactly (W−ZF+1) + N + 1 rising edges after the edge that samples `start_i`. N = FB + (FB≥4) + (FB≥13) is the iteration count, which includes the repeated indices 4 and 13. With the defaults (W=14, ZF=9, G=5) this gives 27 edges. For W=12 it gives 25 edges.
- R6: `done_o` and `res_o` stay unchanged after completion until the next start. A start accepted while idle drives `done_o` low on the next edge.
- R7: A start pulse that arrives while an evaluation is running is ignored. It changes neither that evaluation's result nor its completion time.
- R8: The 12-bit (ZF=7) and 14-bit (ZF=9) configurations both meet R2 through R5.
- R9: `res_o` never exceeds 2^(W−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; sampled only when idle |
| z_i | input | W | Unsigned argument with ZF fraction bits |
| res_o | output | W | e^(−z), unsigned with W−1 fraction bits |
| done_o | output | 1 | High from completion until the next accepted start |

## Verification
Arguments just below and just above ln2 show whether the range reduction chooses the right k at its first boundary. Arguments between 1.1 and W·ln2 show whether the extension goes past the basic rotation limit and whether the final right shift is correct. Arguments past W·ln2, and the maximum code, must give an exact zero. Seeded random arguments over the whole code space, run on both word widths, then compare each result with a real-valued exponential. A second start during a running evaluation, together with a long idle wait after completion, separates the ignore rule from the hold rule.

// File: rtl/ncx_pkg.sv
package ncx_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RED  = 2'd1,
        S_ROT  = 2'd2,
        S_FIN  = 2'd3
    } ncx_state_e;

    // Iteration step -> hyperbolic index; indices 4 and 13 are visited twice
    function automatic int step_to_idx(input int s);
        if (s < 4)
            return s + 1;
        else if (s < 14)
            return s;
        else
            return s - 1;
    endfunction

    // Number of iterations needed to reach index fb including repeats
    function automatic int iter_count(input int fb);
        int n;
        n = fb;
        if (fb >= 4)  n = n + 1;
        if (fb >= 13) n = n + 1;
        return n;
    endfunction

    function automatic real atanh_r(input real t);
        return 0.5 * $ln((1.0 + t) / (1.0 - t));
    endfunction

    // Inverse of the accumulated hyperbolic gain over all iterations
    function automatic real inv_gain(input int nsteps);
        real p;
        real t;
        p = 1.0;
        for (int s = 0; s < nsteps; s++) begin
            t = 1.0 / (2.0 ** step_to_idx(s));
            p = p * (1.0 - t * t);
        end
        return 1.0 / $sqrt(p);
    endfunction

    function automatic int to_fix(input real v, input int fb);
        return $rtoi(v * (2.0 ** fb) + 0.5);
    endfunction

endpackage

// File: rtl/ncx_atanh_rom.sv
module ncx_atanh_rom
    import ncx_pkg::*;
#(
    parameter int AW    = 25,
    parameter int FB    = 18,
    parameter int NSTEP = 20,
    parameter int SW    = 5
) (
    input  logic [SW-1:0]        step_i,
    output logic signed [AW-1:0] ang_o,
    output logic [SW-1:0]        shift_o
);

    logic signed [AW-1:0] tab    [NSTEP];
    logic [SW-1:0]        sh_tab [NSTEP];

    generate
        for (genvar s = 0; s < NSTEP; s++) begin : g_ent
            localparam int IDX = step_to_idx(s);
            localparam int VAL = to_fix(atanh_r(1.0 / (2.0 ** IDX)), FB);
            assign tab[s]    = AW'(VAL);
            assign sh_tab[s] = SW'(IDX);
        end
    endgenerate

    always_comb begin
        ang_o   = '0;
        shift_o = '0;
        for (int s = 0; s < NSTEP; s++) begin
            if (step_i == SW'(s)) begin
                ang_o   = tab[s];
                shift_o = sh_tab[s];
            end
        end
    end

endmodule

// File: rtl/ncx_rot_stage.sv
module ncx_rot_stage #(
    parameter int AW = 25,
    parameter int SW = 5
) (
    input  logic signed [AW-1:0] x_i,
    input  logic signed [AW-1:0] y_i,
    input  logic signed [AW-1:0] ang_i,
    input  logic signed [AW-1:0] atanh_i,
    input  logic [SW-1:0]        sh_i,
    output logic signed [AW-1:0] x_o,
    output logic signed [AW-1:0] y_o,
    output logic signed [AW-1:0] ang_o
);

    logic signed [AW-1:0] xs;
    logic signed [AW-1:0] ys;

    always_comb begin
        xs = x_i >>> sh_i;
        ys = y_i >>> sh_i;
        if (!ang_i[AW-1]) begin
            x_o   = x_i + ys;
            y_o   = y_i + xs;
            ang_o = ang_i - atanh_i;
        end else begin
            x_o   = x_i - ys;
            y_o   = y_i - xs;
            ang_o = ang_i + atanh_i;
        end
    end

endmodule

// File: rtl/ncx_scale.sv
module ncx_scale #(
    parameter int W  = 14,
    parameter int AW = 25,
    parameter int KB = 6,
    parameter int G  = 5
) (
    input  logic signed [AW-1:0] x_i,
    input  logic signed [AW-1:0] y_i,
    input  logic [KB-1:0]        k_i,
    output logic [W-1:0]         res_o
);

    localparam logic [AW-1:0] ONE_OUT = AW'(1) << (W - 1);

    logic signed [AW-1:0] diff;
    logic [AW-1:0]        mag;
    logic [AW-1:0]        rnd;
    logic [AW-1:0]        shv;
    int                   sh;

    always_comb begin
        diff  = x_i - y_i;
        mag   = diff[AW-1] ? '0 : diff;
        sh    = G;
        rnd   = '0;
        shv   = '0;
        res_o = '0;
        if (int'(k_i) < W) begin
            sh    = G + int'(k_i);
            rnd   = mag + (AW'(1) << (sh - 1));
            shv   = rnd >> sh;
            res_o = (shv > ONE_OUT) ? ONE_OUT[W-1:0] : shv[W-1:0];
        end
    end

endmodule

// File: rtl/ncx_exp_neg.sv
module ncx_exp_neg
    import ncx_pkg::*;
#(
    parameter int W  = 14,
    parameter int ZF = W - 5,
    parameter int G  = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] res_o,
    output logic         done_o
);

    localparam int FB    = W - 1 + G;
    localparam int ZI    = W - ZF;
    localparam int KB    = ZI + 1;
    localparam int AW    = ZI + FB + 2;
    localparam int NSTEP = iter_count(FB);
    localparam int SMAX  = (NSTEP > KB) ? NSTEP : KB;
    localparam int SW    = $clog2(SMAX + 1);

    localparam logic signed [AW-1:0] LN2_F  = AW'(to_fix($ln(2.0), FB));
    localparam logic signed [AW-1:0] INVK_F = AW'(to_fix(inv_gain(NSTEP), FB));
    localparam logic [W-1:0]         ONE_RES = W'(1) << (W - 1);

    typedef struct packed {
        ncx_state_e           st;
        logic [SW-1:0]        step;
        logic [KB-1:0]        k;
        logic signed [AW-1:0] x;
        logic signed [AW-1:0] y;
        logic signed [AW-1:0] ang;
        logic [W-1:0]         res;
        logic                 done;
    } ncx_reg_t;

    ncx_reg_t r_q, r_d;

    logic signed [AW-1:0] atanh_c;
    logic [SW-1:0]        sh_c;
    logic signed [AW-1:0] x_nx, y_nx, ang_nx;
    logic [W-1:0]         scaled;
    logic signed [AW-1:0] ln2_sh;

    ncx_atanh_rom #(.AW(AW), .FB(FB), .NSTEP(NSTEP), .SW(SW)) u_rom (
        .step_i  (r_q.step),
        .ang_o   (atanh_c),
        .shift_o (sh_c)
    );

    ncx_rot_stage #(.AW(AW), .SW(SW)) u_stage (
        .x_i     (r_q.x),
        .y_i     (r_q.y),
        .ang_i   (r_q.ang),
        .atanh_i (atanh_c),
        .sh_i    (sh_c),
        .x_o     (x_nx),
        .y_o     (y_nx),
        .ang_o   (ang_nx)
    );

    ncx_scale #(.W(W), .AW(AW), .KB(KB), .G(G)) u_scale (
        .x_i   (r_q.x),
        .y_i   (r_q.y),
        .k_i   (r_q.k),
        .res_o (scaled)
    );

    always_comb begin
        r_d    = r_q;
        ln2_sh = LN2_F <<< r_q.step;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.st   = S_RED;
                    r_d.ang  = $signed({{(AW-W){1'b0}}, z_i}) <<< (FB - ZF);
                    r_d.k    = '0;
                    r_d.step = SW'(KB - 1);
                    r_d.done = 1'b0;
                end
            end
            S_RED: begin
                if (r_q.ang >= ln2_sh) begin
                    r_d.ang = r_q.ang - ln2_sh;
                    r_d.k   = r_q.k | (KB'(1) << r_q.step);
                end
                if (r_q.step == '0) begin
                    r_d.st = S_ROT;
                    r_d.x  = INVK_F;
                    r_d.y  = '0;
                end else begin
                    r_d.step = r_q.step - 1'b1;
                end
            end
            S_ROT: begin
                r_d.x   = x_nx;
                r_d.y   = y_nx;
                r_d.ang = ang_nx;
                if (r_q.step == SW'(NSTEP - 1))
                    r_d.st = S_FIN;
                else
                    r_d.step = r_q.step + 1'b1;
            end
            S_FIN: begin
                r_d.res  = scaled;
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign res_o  = r_q.res;
    assign done_o = r_q.done;

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !start_i) |=> (done_o && $stable(res_o))); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && start_i) |=> !done_o); // R6
    AST_RES_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        res_o <= ONE_RES); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_ROT && start_i) |=> (r_q.st == S_ROT || r_q.st == S_FIN)); // R7
    AST_FRAC_BELOW_LN2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_ROT && r_q.step == '0) |-> (!r_q.ang[AW-1] && r_q.ang < LN2_F)); // R4
    AST_ZERO_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_FIN && int'(r_q.k) >= W) |=> (res_o == '0)); // R3
    AST_ANGLE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_FIN) |-> (r_q.ang < 16 && r_q.ang > -16)); // R2

endmodule

// File: tb/ncx_exp_neg_bench.sv
module ncx_exp_neg_bench;

    localparam real LN2 = 0.6931471805599453;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st14 = 1'b0, st12 = 1'b0;
    logic [13:0] z14 = '0;
    logic [11:0] z12 = '0;
    logic [13:0] r14;
    logic [11:0] r12;
    logic        d14, d12;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ncx_exp_neg u_ncx_exp_neg (
        .clk(clk), .rst_n(rst_n), .start_i(st14), .z_i(z14), .res_o(r14), .done_o(d14)
    );

    ncx_exp_neg #(.W(12)) u_ncx_exp_neg_w12 (
        .clk(clk), .rst_n(rst_n), .start_i(st12), .z_i(z12), .res_o(r12), .done_o(d12)
    );

    function automatic int ref_q(input int z, input int w, input int zf);
        real zr;
        zr = real'(z) / (2.0 ** zf);
        return $rtoi($exp(-zr) * (2.0 ** (w - 1)) + 0.5);
    endfunction

    function automatic bit zero_zone(input int z, input int w, input int zf);
        return (real'(z) / (2.0 ** zf)) >= (real'(w) + 0.05) * LN2;
    endfunction

    function automatic int lat_of(input int w, input int g);
        int fb, zf, n;
        fb = w - 1 + g;
        zf = w - 5;
        n  = fb + ((fb >= 4) ? 1 : 0) + ((fb >= 13) ? 1 : 0);
        return (w - zf + 1) + n + 1;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_one(input bit wide, input int z, output int res, output int lat);
        @(negedge clk);
        if (wide) begin z14 = 14'(z); st14 = 1'b1; end
        else      begin z12 = 12'(z); st12 = 1'b1; end
        @(negedge clk);
        st14 = 1'b0; st12 = 1'b0;
        check((wide ? d14 : d12) == 1'b0, "R6 done cleared by start", int'(wide ? d14 : d12), 0);
        lat = 0;
        while (!(wide ? d14 : d12) && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        res = wide ? int'(r14) : int'(r12);
    endtask

    task automatic check_val(input bit wide, input int z, input int res, input string tag);
        int w, zf, e, diff;
        w  = wide ? 14 : 12;
        zf = w - 5;
        e  = ref_q(z, w, zf);
        diff = res - e;
        if (diff < 0) diff = -diff;
        if (zero_zone(z, w, zf))
            check(res == 0, {"R3 zero region ", tag}, res, 0);
        else
            check(diff <= 2, {tag, " value"}, res, e);
        check(res <= (1 << (w - 1)), "R9 ceiling", res, 1 << (w - 1));
    endtask

    task automatic eval(input bit wide, input int z, input string tag);
        int res, lat, w;
        w = wide ? 14 : 12;
        run_one(wide, z, res, lat);
        check(lat == lat_of(w, 5), {"R5 latency ", tag}, lat, lat_of(w, 5));
        check_val(wide, z, res, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 150000, 0);
        report();
        $finish;
    end

    initial begin
        int seed, res, lat, hold_res;
        bit stable;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(r14 == 0 && d14 == 1'b0, "R1 reset w14", int'(r14), 0);
        check(r12 == 0 && d12 == 1'b0, "R1 reset w12", int'(r12), 0);
        rst_n = 1'b1;

        // R2 core range, both widths (R8)
        eval(1'b1, 0,   "R2 z=0 w14");
        eval(1'b1, 353, "R2 below ln2 w14");
        eval(1'b1, 128, "R2 z=0.25 w14");
        eval(1'b0, 0,   "R8 R2 z=0 w12");
        eval(1'b0, 88,  "R8 R2 below ln2 w12");
        // R4 extended range
        eval(1'b1, 355,  "R4 above ln2 w14");
        eval(1'b1, 768,  "R4 z=1.5 w14");
        eval(1'b1, 2560, "R4 z=5 w14");
        eval(1'b1, 4600, "R4 z near top w14");
        eval(1'b0, 192,  "R8 R4 z=1.5 w12");
        eval(1'b0, 640,  "R8 R4 z=5 w12");
        // R3 zero region
        eval(1'b1, 5120,  "R3 z=10 w14");
        eval(1'b1, 16383, "R3 max w14");
        eval(1'b0, 4095,  "R8 R3 max w12");

        // R6 hold after completion
        run_one(1'b1, 300, res, lat);
        hold_res = int'(r14);
        stable = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (int'(r14) != hold_res || !d14) stable = 1'b0;
        end
        check(stable, "R6 result held while idle", int'(r14), hold_res);

        // R7 start while busy is ignored
        @(negedge clk);
        z14 = 14'd768; st14 = 1'b1;
        @(negedge clk);
        st14 = 1'b0;
        lat = 0;
        repeat (12) begin @(negedge clk); lat++; end
        z14 = 14'd5120; st14 = 1'b1;
        @(negedge clk);
        st14 = 1'b0; lat++;
        while (!d14 && lat < 1000) begin @(negedge clk); lat++; end
        check(lat == lat_of(14, 5), "R7 timing unchanged by busy start", lat, lat_of(14, 5));
        check(int'(r14) - ref_q(768, 14, 9) <= 2 && ref_q(768, 14, 9) - int'(r14) <= 2,
              "R7 result unchanged by busy start", int'(r14), ref_q(768, 14, 9));

        // Random arguments, both widths
        for (int i = 0; i < 40; i++) eval(1'b1, int'($urandom % 16384), "R2/R4 random w14");
        for (int i = 0; i < 40; i++) eval(1'b0, int'($urandom % 4096), "R8 random w12");

        report();
        $finish;
    end

endmodule